// File: doc/BRIEF.md
# Shared Reorder-Buffer Thread Quota Controller

This block decides how many entries of a reorder buffer that is shared by several hardware threads each thread may hold. A policy code picks one of three sharing schemes: every thread may use the whole buffer, the buffer is split evenly among threads, or each thread is held to a fixed threshold. The per-thread entry limits sit in a register. They are reloaded when reset is applied or when the policy code changes. They are recomputed when the mask of active threads changes.

Occupancy counts for each thread come from the buffer itself, which is outside this block. From those counts and the registered limits, the block produces a free count for each thread and one for the whole buffer. It also produces a stall flag for each thread that the dispatch stage uses to hold back new instructions. A policy code that is not supported raises an error flag and drives every limit to zero.

Top module: `smt_rob_share`

## Requirements
- R1: With policy code 0 (dynamic), every thread limit equals the buffer capacity CAP.
- R2: With policy code 1 (partitioned), reset loads every thread limit with CAP divided by NT using integer division.
- R3: With policy code 2 (threshold), reset loads every thread limit with the parameter TH.
- R4: Under code 1, a change of the active mask to a non-empty set gives every active thread the limit CAP divided by the number of active threads, visible one clock after the change. Inactive threads keep their previous limit.
- R5: Under code 2, a change of the active mask to exactly one active thread gives that thread the limit CAP one clock later. No other mask change alters any limit under code 2.
- R6: A change of the active mask to all zeros performs no division, and every limit keeps its previous value.
- R7: The free count of a thread is its limit minus its occupancy, clamped at zero when occupancy exceeds the limit.
- R8: The global free count is CAP minus the sum of all occupancies, clamped at zero.
- R9: A thread's stall flag is high exactly when its own free count is zero or the global free count is zero.
- R10: Policy code 3 raises the error flag in the same cycle. From the next clock on, and for as long as the code persists, every limit is zero.
- R11: A change of the policy code without reset reloads every limit, one clock later, with that policy's reset value from R1 to R3 (zero for code 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_i | input | 2 | Sharing policy code (0 dynamic, 1 partitioned, 2 threshold, 3 unsupported) |
| act_mask_i | input | NT | One bit per thread, high when that thread is active |
| occ_i | input | NT*CNT_W | Per-thread occupancy counts; thread t is in bits [t*CNT_W +: CNT_W] |
| limit_o | output | NT*CNT_W | Per-thread entry limits, packed the same way as occ_i |
| free_o | output | NT*CNT_W | Per-thread free counts, packed the same way as occ_i |
| glob_free_o | output | CNT_W | Free entries in the whole buffer |
| stall_o | output | NT | Per-thread dispatch stall |
| pol_err_o | output | 1 | High while the policy code is unsupported |

## Verification
The limit register is the only state that matters. If it is corrupted, limit_o shows the wrong value one clock after the mask or policy change that produced it, and free_o and stall_o go wrong in the same cycle because they are combinational on that register. The stored copies of the previous mask and policy are the other risk. If one of them is stale, a recompute is either missed or done twice, and this is seen when an inactive thread's limit moves, or when a thread keeps an old limit after a mask sweep. A sweep through all active masks under each policy, compared against an arithmetic model of the quota rules, exposes either fault within one clock.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;

    typedef enum logic [1:0] {
        POL_DYN    = 2'd0,
        POL_PART   = 2'd1,
        POL_THRESH = 2'd2,
        POL_BAD    = 2'd3
    } share_pol_e;

    function automatic logic pol_is_valid(input logic [1:0] p);
        return p != POL_BAD;
    endfunction

    // Limit loaded at reset or on a policy change.
    function automatic int unsigned start_limit(input logic [1:0] p,
                                                input int unsigned cap,
                                                input int unsigned nt,
                                                input int unsigned th);
        case (p)
            POL_DYN:    return cap;
            POL_PART:   return cap / nt;
            POL_THRESH: return th;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/rob_share_limit.sv
module rob_share_limit
    import rob_share_pkg::*;
#(
    parameter int NT    = 4,
    parameter int CAP   = 32,
    parameter int TH    = 12,
    parameter int CNT_W = 6
) (
    input  logic [1:0]          pol,
    input  logic                pol_chg,
    input  logic [NT-1:0]       mask,
    input  logic                mask_chg,
    input  logic [NT*CNT_W-1:0] lim_q,
    output logic [NT*CNT_W-1:0] lim_d
);
    localparam int CW   = $clog2(NT + 1);
    localparam int QN   = 2 ** CW;

    // Constant quotient table: CAP / k for every possible active count.
    logic [CNT_W-1:0] quot [QN];
    for (genvar k = 0; k < QN; k++) begin : g_quot
        if (k == 0 || k > NT) begin : g_zero
            assign quot[k] = '0;
        end else begin : g_div
            assign quot[k] = CNT_W'(CAP / k);
        end
    end

    logic [CW-1:0]    n_act;
    logic [CNT_W-1:0] init_val;
    assign n_act    = CW'($countones(mask));
    assign init_val = CNT_W'(start_limit(pol, CAP, NT, TH));

    always_comb begin
        lim_d = lim_q;
        for (int t = 0; t < NT; t++) begin
            if (!pol_is_valid(pol)) begin
                lim_d[t*CNT_W +: CNT_W] = '0;
            end else if (pol_chg) begin
                lim_d[t*CNT_W +: CNT_W] = init_val;
            end else if (mask_chg && n_act != '0) begin
                case (pol)
                    POL_PART: begin
                        if (mask[t]) lim_d[t*CNT_W +: CNT_W] = quot[n_act];
                    end
                    POL_THRESH: begin
                        if (mask[t] && n_act == CW'(1))
                            lim_d[t*CNT_W +: CNT_W] = CNT_W'(CAP);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rob_share_free.sv
module rob_share_free #(
    parameter int NT    = 4,
    parameter int CAP   = 32,
    parameter int CNT_W = 6
) (
    input  logic [NT*CNT_W-1:0] lim,
    input  logic [NT*CNT_W-1:0] occ,
    output logic [NT*CNT_W-1:0] thr_free,
    output logic [CNT_W-1:0]    glob_free,
    output logic [NT-1:0]       stall
);
    localparam int SUM_W = CNT_W + $clog2(NT) + 1;

    logic [SUM_W-1:0] occ_sum;

    always_comb begin
        occ_sum = '0;
        for (int t = 0; t < NT; t++)
            occ_sum = occ_sum + SUM_W'(occ[t*CNT_W +: CNT_W]);
        glob_free = (occ_sum >= SUM_W'(CAP)) ? '0 : CNT_W'(SUM_W'(CAP) - occ_sum);
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [CNT_W-1:0] l_t, o_t, f_t;
        assign l_t = lim[t*CNT_W +: CNT_W];
        assign o_t = occ[t*CNT_W +: CNT_W];
        assign f_t = (o_t >= l_t) ? '0 : l_t - o_t;
        assign thr_free[t*CNT_W +: CNT_W] = f_t;
        assign stall[t] = (f_t == '0) || (glob_free == '0);
    end

endmodule

// File: rtl/smt_rob_share.sv
module smt_rob_share
    import rob_share_pkg::*;
#(
    parameter int NT  = 4,
    parameter int CAP = 32,
    parameter int TH  = 12,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          pol_i,
    input  logic [NT-1:0]       act_mask_i,
    input  logic [NT*CNT_W-1:0] occ_i,
    output logic [NT*CNT_W-1:0] limit_o,
    output logic [NT*CNT_W-1:0] free_o,
    output logic [CNT_W-1:0]    glob_free_o,
    output logic [NT-1:0]       stall_o,
    output logic                pol_err_o
);
    logic [NT*CNT_W-1:0] lim_q, lim_d;
    logic [1:0]          prev_pol;
    logic [NT-1:0]       prev_mask;
    logic [CNT_W-1:0]    rst_val;

    assign rst_val = CNT_W'(start_limit(pol_i, CAP, NT, TH));

    rob_share_limit #(.NT(NT), .CAP(CAP), .TH(TH), .CNT_W(CNT_W)) u_limit (
        .pol      (pol_i),
        .pol_chg  (pol_i != prev_pol),
        .mask     (act_mask_i),
        .mask_chg (act_mask_i != prev_mask),
        .lim_q    (lim_q),
        .lim_d    (lim_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q     <= {NT{rst_val}};
            prev_pol  <= pol_i;
            prev_mask <= act_mask_i;
        end else begin
            lim_q     <= lim_d;
            prev_pol  <= pol_i;
            prev_mask <= act_mask_i;
        end
    end

    rob_share_free #(.NT(NT), .CAP(CAP), .CNT_W(CNT_W)) u_free (
        .lim       (lim_q),
        .occ       (occ_i),
        .thr_free  (free_o),
        .glob_free (glob_free_o),
        .stall     (stall_o)
    );

    assign limit_o   = lim_q;
    assign pol_err_o = !pol_is_valid(pol_i);

    // R1: dynamic sharing keeps every limit at full capacity
    p_dyn_full_r1: assert property (@(posedge clk) disable iff (rst)
        (pol_i == POL_DYN && prev_pol == POL_DYN) |-> limit_o == {NT{CNT_W'(CAP)}});

    // R10: unsupported code holds limits at zero
    p_bad_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (pol_i == POL_BAD && prev_pol == POL_BAD) |-> limit_o == '0);

    // R6: empty active set leaves limits untouched
    p_hold_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (pol_i == prev_pol && act_mask_i != prev_mask && act_mask_i == '0)
        |=> $stable(limit_o));

    // R9: a full buffer stalls every thread
    p_full_stall_r9: assert property (@(posedge clk) disable iff (rst)
        glob_free_o == '0 |-> stall_o == '1);

    // R8: global free never exceeds capacity
    p_gfree_cap_r8: assert property (@(posedge clk) disable iff (rst)
        int'(glob_free_o) <= CAP);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        // R7: a thread's free count never exceeds its limit
        p_free_le_lim_r7: assert property (@(posedge clk) disable iff (rst)
            free_o[t*CNT_W +: CNT_W] <= limit_o[t*CNT_W +: CNT_W]);

        // R4: partitioned recompute gives active threads an even share
        p_part_share_r4: assert property (@(posedge clk) disable iff (rst)
            (pol_i == POL_PART && prev_pol == POL_PART &&
             act_mask_i != prev_mask && act_mask_i[t])
            |=> int'(limit_o[t*CNT_W +: CNT_W]) == CAP / $countones($past(act_mask_i)));
    end

endmodule

// File: tb/sim_smt_rob_share.sv
module sim_smt_rob_share;
    localparam int NT  = 4;
    localparam int CAP = 32;
    localparam int TH  = 12;
    localparam int W   = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      pol_i = 2'd1;
    logic [NT-1:0]   act_mask_i = '1;
    logic [NT*W-1:0] occ_i = '0;
    logic [NT*W-1:0] limit_o, free_o;
    logic [W-1:0]    glob_free_o;
    logic [NT-1:0]   stall_o;
    logic            pol_err_o;

    always #2 clk = ~clk;

    smt_rob_share #(.NT(NT), .CAP(CAP), .TH(TH)) u0 (
        .clk(clk), .rst(rst), .pol_i(pol_i), .act_mask_i(act_mask_i),
        .occ_i(occ_i), .limit_o(limit_o), .free_o(free_o),
        .glob_free_o(glob_free_o), .stall_o(stall_o), .pol_err_o(pol_err_o)
    );

    int total = 0;
    int bad = 0;
    int exp_lim [NT];
    logic [NT-1:0] cur_mask = '1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int start_of(input int p);
        case (p)
            0: return CAP;
            1: return CAP / NT;
            2: return TH;
            default: return 0;
        endcase
    endfunction

    task automatic check_lims(input string req);
        for (int t = 0; t < NT; t++)
            chk(req, int'(limit_o[t*W +: W]), exp_lim[t]);
    endtask

    task automatic do_reset(input int p);
        pol_i = 2'(p);
        act_mask_i = '1;
        cur_mask = '1;
        occ_i = '0;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        for (int t = 0; t < NT; t++) exp_lim[t] = start_of(p);
    endtask

    task automatic apply_mask(input logic [NT-1:0] m, input string req);
        int n;
        n = $countones(m);
        if (m != cur_mask && n != 0) begin
            for (int t = 0; t < NT; t++) begin
                if (m[t] && pol_i == 2'd1) exp_lim[t] = CAP / n;
                if (m[t] && pol_i == 2'd2 && n == 1) exp_lim[t] = CAP;
            end
        end
        cur_mask = m;
        act_mask_i = m;
        tick();
        check_lims(req);
    endtask

    task automatic free_sweep(input string tag);
        int o [NT];
        int sum, ef, eg;
        for (int a = 0; a < 12; a++) begin
            sum = 0;
            for (int t = 0; t < NT; t++) begin
                o[t] = (a * 5 + t * 7) % 12;
                occ_i[t*W +: W] = W'(o[t]);
                sum += o[t];
            end
            tick();
            eg = (sum >= CAP) ? 0 : CAP - sum;
            chk({"R8 ", tag}, int'(glob_free_o), eg);
            for (int t = 0; t < NT; t++) begin
                ef = (o[t] >= exp_lim[t]) ? 0 : exp_lim[t] - o[t];
                chk({"R7 ", tag}, int'(free_o[t*W +: W]), ef);
                chk({"R9 ", tag}, int'(stall_o[t]), (ef == 0 || eg == 0) ? 1 : 0);
            end
        end
        occ_i = '0;
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2 reset values, then partitioned sweep (R4, R6)
        do_reset(1);
        check_lims("R2 reset");
        chk("R10 err low", int'(pol_err_o), 0);
        chk("R8 reset gfree", int'(glob_free_o), CAP);
        free_sweep("partitioned");
        for (int m = 0; m < 16; m++) apply_mask(4'(m), "R4 R6 part sweep");
        for (int m = 15; m >= 0; m--) apply_mask(4'(m), "R4 R6 part down");

        // R3 reset values, then threshold sweep (R5, R6)
        do_reset(2);
        check_lims("R3 reset");
        apply_mask(4'b0000, "R6 thresh empty");
        apply_mask(4'b0011, "R5 thresh two");
        for (int m = 0; m < 16; m++) apply_mask(4'(m), "R5 thresh sweep");

        // R1 dynamic under all masks, full buffer stall
        do_reset(0);
        check_lims("R1 reset");
        for (int m = 0; m < 16; m++) apply_mask(4'(m), "R1 dyn sweep");
        free_sweep("dynamic");
        for (int t = 0; t < NT; t++) occ_i[t*W +: W] = W'(8);
        tick();
        chk("R8 exact full", int'(glob_free_o), 0);
        chk("R9 full stall", int'(stall_o), 15);
        chk("R7 full free", int'(free_o[0 +: W]), CAP - 8);
        for (int t = 0; t < NT; t++) occ_i[t*W +: W] = W'(10);
        tick();
        chk("R8 oversum", int'(glob_free_o), 0);
        occ_i = '0;

        // R11 policy change without reset, R10 unsupported code
        pol_i = 2'd2;
        tick();
        for (int t = 0; t < NT; t++) exp_lim[t] = TH;
        check_lims("R11 to thresh");
        pol_i = 2'd3;
        chk("R10 err same cycle", int'(pol_err_o), 1);
        tick();
        for (int t = 0; t < NT; t++) exp_lim[t] = 0;
        check_lims("R10 zero");
        apply_mask(4'b0001, "R10 mask ignored");
        tick();
        check_lims("R10 held");
        chk("R9 zero limit stall", int'(stall_o), 15);
        pol_i = 2'd1;
        tick();
        for (int t = 0; t < NT; t++) exp_lim[t] = CAP / NT;
        check_lims("R11 to part");
        chk("R10 err clear", int'(pol_err_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule